// File: doc/BRIEF.md
# SPI Master/Slave Port with Fault Detection

This block is a full-duplex serial peripheral port that works either as the bus master or as a slave. It has a small register file with four addresses: control, target select, status and data. In master mode, a write to the data register starts an 8-bit exchange. The block then generates SCK at one of four rates, pulls low the slave-select output of the chosen target, and shifts one byte out on MOSI while it shifts one byte in on MISO. In slave mode, software preloads the byte to send, and an external master clocks the exchange while it holds the select input low.

The sequencer has four named states. ST_IDLE waits. ST_MSHIFT generates the sixteen SCK edges of a master byte. ST_MHOLD keeps the select line asserted for one more half period. ST_SLAVE follows the external clock while the port is selected. The transitions are:

- idle→mshift: a data write while enabled as master.
- mshift→mhold: the sixteenth edge.
- mhold→idle: end of the hold half period.
- idle→slave: select goes low while enabled as slave.
- slave→idle: select rises, or the port is disabled or turned into a master.
- mshift/mhold→idle: a mode fault or a disable.

Every pin input passes through a two-stage synchronizer before use. When the port is master, the MISO sample is delayed by the same two cycles so that the master can run at CLK/4.

Top module: `spi_port`

## Requirements
- R1: After reset, CTRL (address 0), SEL (address 1) and STAT (address 2) read 0x00. All bits of sso_n are high, every output enable is low and irq is low.
- R2: In master mode the SCK half period is 2^(RATE+1) clock cycles, where RATE is CTRL[1:0]. The encodings 00, 01, 10 and 11 give SCK at CLK/4, CLK/8, CLK/16 and CLK/32.
- R3: CTRL[5] (CPOL) sets the idle level of SCK. With CTRL[4] (CPHA) at 0, data is valid before the first edge and is sampled on odd-numbered edges. With CPHA at 1, data changes on odd-numbered edges and is sampled on even-numbered edges. Bits go MSB first and each byte takes 16 edges. While a transfer runs, writes to CPOL, CPHA and RATE are ignored.
- R4: A write to DATA (address 3) while idle, with CTRL[7] (EN) and CTRL[6] (MSTR) set, starts an exchange. Afterwards the slave has received the written byte and DATA reads the byte that came in on MISO.
- R5: During a master transfer, sso_n[SEL[2:0]] is low and every other bit of sso_n is high. All bits are high while idle.
- R6: STAT[7] (done) sets at the end of every byte, in either mode. irq equals CTRL[3] AND (STAT[7] OR STAT[5]). Writing 1 to a STAT bit clears that bit.
- R7: A DATA write during a transfer sets STAT[6] (write collision) and is discarded. The transfer in progress completes with its original byte.
- R8: If the synchronized ss_n_in is low while EN and MSTR are set, STAT[5] (mode fault) sets, MSTR clears, and sck_oe and mosi_oe go low. While STAT[5] is set, every output enable stays low.
- R9: In slave mode (EN=1, MSTR=0) with ss_n_in low, the port exchanges a byte with an external master whose SCK half period is at least 8 clock cycles. It drives miso_out with miso_oe high, sending the byte last written to DATA, and DATA then reads the byte received on MOSI.
- R10: In slave mode, activity on sck_in and mosi_in while ss_n_in is high has no effect: STAT[7] stays clear and DATA keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | Drive enable for sck_out |
| mosi_in | input | 1 | Serial data in, slave mode |
| mosi_out | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Drive enable for mosi_out |
| miso_in | input | 1 | Serial data in, master mode |
| miso_out | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Drive enable for miso_out |
| ss_n_in | input | 1 | Active-low select input |
| sso_n | output | 8 | Active-low slave-select outputs |

## Verification
Master exchanges are run in all four clocking modes, at every rate and for every target, with all-zero, all-one, alternating and random bytes. Byte pairs whose two bits differ at every position expose any swap between the MOSI and MISO paths, and the CLK/4 runs show whether the delayed MISO sample lands in the right cycle. Slave exchanges use the same byte patterns under a bench-driven master, which separates the sample edge from the launch edge for each phase setting. Directed cases add a write during a transfer, a mode-field write during a transfer, a select fault while master, and clock toggling while deselected.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MSHIFT = 2'd1,
        ST_MHOLD  = 2'd2,
        ST_SLAVE  = 2'd3
    } spi_state_e;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_SEL  = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_DATA = 2'd3;

    typedef struct packed {
        logic       en;
        logic       mstr;
        logic       cpol;
        logic       cpha;
        logic       ie;
        logic       spare;
        logic [1:0] rate;
    } ctrl_t;

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CNT_W = (1 << RATE_W) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // half period = 2^(rate+1) cycles
    assign lim  = (CNT_W'(2) << rate) - CNT_W'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/spi_port_engine.sv
module spi_port_engine
    import spi_port_pkg::*;
#(
    parameter int DW = 8,
    parameter int RATE_W = 2,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mstr,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [RATE_W-1:0] rate,
    input  logic              fault,
    input  logic              load,
    input  logic [DW-1:0]     wdata,
    input  logic              sck_s,
    input  logic              miso_s,
    input  logic              mosi_s,
    input  logic              ss_s,
    output logic              busy,
    output logic              m_act,
    output logic              sck_o,
    output logic              out_bit,
    output logic [DW-1:0]     rx_byte,
    output logic              done
);
    localparam int EC_W = $clog2(2 * DW);
    localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(2 * DW - 1);

    spi_state_e      state, nstate;
    logic [EC_W-1:0] ecnt;
    logic            sck_q, sck_prev;
    logic [DW-1:0]   tx_sr, rx_sr;
    logic [SYNC-1:0] samp_pipe;
    logic            run, tick, m_edge, s_edge, any_edge, is_samp, is_shift;

    assign run = (state == ST_MSHIFT) || (state == ST_MHOLD);

    spi_port_clkgen #(.RATE_W(RATE_W)) u_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .rate (rate),
        .tick (tick)
    );

    assign m_edge   = (state == ST_MSHIFT) && tick;
    assign s_edge   = (state == ST_SLAVE) && (sck_s != sck_prev);
    assign any_edge = m_edge || s_edge;
    // edge index 0 is the first (leading) edge
    assign is_samp  = cpha ? ecnt[0] : ~ecnt[0];
    assign is_shift = cpha ? (~ecnt[0] && (ecnt != '0)) : ecnt[0];

    // next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (en && mstr && load)        nstate = ST_MSHIFT;
                else if (en && !mstr && !ss_s) nstate = ST_SLAVE;
            end
            ST_MSHIFT: begin
                if (fault || !en)                       nstate = ST_IDLE;
                else if (m_edge && (ecnt == LAST_EDGE)) nstate = ST_MHOLD;
            end
            ST_MHOLD: begin
                if (fault || !en || tick) nstate = ST_IDLE;
            end
            ST_SLAVE: begin
                if (!en || mstr || ss_s) nstate = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecnt      <= '0;
            sck_q     <= 1'b0;
            sck_prev  <= 1'b0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            samp_pipe <= '0;
        end else begin
            sck_prev  <= sck_s;
            samp_pipe <= (samp_pipe << 1) | SYNC'(m_edge && is_samp);

            if (state == ST_IDLE)  ecnt <= '0;
            else if (any_edge)     ecnt <= ecnt + EC_W'(1);

            if (!run)        sck_q <= cpol;
            else if (m_edge) sck_q <= ~sck_q;

            if (load)                      tx_sr <= wdata;
            else if (any_edge && is_shift) tx_sr <= {tx_sr[DW-2:0], 1'b0};

            // slave samples synced MOSI at once; master samples MISO after sync delay
            if (s_edge && is_samp)         rx_sr <= {rx_sr[DW-2:0], mosi_s};
            else if (samp_pipe[SYNC-1])    rx_sr <= {rx_sr[DW-2:0], miso_s};
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        m_act   = run;
        sck_o   = sck_q;
        out_bit = tx_sr[DW-1];
        rx_byte = rx_sr;
        done    = ((state == ST_MHOLD) && tick && en && !fault) ||
                  (s_edge && (ecnt == LAST_EDGE));
    end

    // R3
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MHOLD) |-> (sck_o == cpol));

endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW = 8,
    parameter int N_SSO = 8,
    parameter int RATE_W = 2,
    parameter int SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic             mosi_in,
    output logic             mosi_out,
    output logic             mosi_oe,
    input  logic             miso_in,
    output logic             miso_out,
    output logic             miso_oe,
    input  logic             ss_n_in,
    output logic [N_SSO-1:0] sso_n
);
    localparam int TGT_W = (N_SSO > 1) ? $clog2(N_SSO) : 1;

    ctrl_t            ctrl_q;
    logic [TGT_W-1:0] tgt_q;
    logic             done_q, wcol_q, modf_q;
    logic             sck_s, mosi_s, miso_s, ss_s;
    logic             busy, m_act, sck_o, out_bit, done, fault;
    logic             ctrl_wr, sel_wr, stat_wr, dat_wr, load;
    logic [DW-1:0]    rx_byte;

    spi_port_sync #(.W(4), .STAGES(SYNC), .RST_VAL(4'b0001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sck_in, mosi_in, miso_in, ss_n_in}),
        .q    ({sck_s, mosi_s, miso_s, ss_s})
    );

    assign ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
    assign sel_wr  = reg_wr && (reg_addr == ADR_SEL);
    assign stat_wr = reg_wr && (reg_addr == ADR_STAT);
    assign dat_wr  = reg_wr && (reg_addr == ADR_DATA);
    assign load    = dat_wr && !busy;
    assign fault   = ctrl_q.en && ctrl_q.mstr && !ss_s;

    spi_port_engine #(.DW(DW), .RATE_W(RATE_W), .SYNC(SYNC)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl_q.en),
        .mstr   (ctrl_q.mstr),
        .cpol   (ctrl_q.cpol),
        .cpha   (ctrl_q.cpha),
        .rate   (ctrl_q.rate),
        .fault  (fault),
        .load   (load),
        .wdata  (reg_wdata),
        .sck_s  (sck_s),
        .miso_s (miso_s),
        .mosi_s (mosi_s),
        .ss_s   (ss_s),
        .busy   (busy),
        .m_act  (m_act),
        .sck_o  (sck_o),
        .out_bit(out_bit),
        .rx_byte(rx_byte),
        .done   (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            tgt_q  <= '0;
            done_q <= 1'b0;
            wcol_q <= 1'b0;
            modf_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.en   <= reg_wdata[7];
                ctrl_q.mstr <= reg_wdata[6];
                ctrl_q.ie   <= reg_wdata[3];
                if (!busy) begin
                    ctrl_q.cpol <= reg_wdata[5];
                    ctrl_q.cpha <= reg_wdata[4];
                    ctrl_q.rate <= reg_wdata[1:0];
                end
            end
            if (fault) ctrl_q.mstr <= 1'b0;
            if (sel_wr) tgt_q <= reg_wdata[TGT_W-1:0];

            if (done)                           done_q <= 1'b1;
            else if (stat_wr && reg_wdata[7])   done_q <= 1'b0;
            if (dat_wr && busy)                 wcol_q <= 1'b1;
            else if (stat_wr && reg_wdata[6])   wcol_q <= 1'b0;
            if (fault)                          modf_q <= 1'b1;
            else if (stat_wr && reg_wdata[5])   modf_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADR_CTRL: reg_rdata = ctrl_q;
            ADR_SEL:  reg_rdata = DW'(tgt_q);
            ADR_STAT: reg_rdata = {done_q, wcol_q, modf_q, {(DW-3){1'b0}}};
            ADR_DATA: reg_rdata = rx_byte;
        endcase
    end

    assign irq      = ctrl_q.ie && (done_q || modf_q);
    assign sck_out  = sck_o;
    assign mosi_out = out_bit;
    assign miso_out = out_bit;
    assign sck_oe   = ctrl_q.en && ctrl_q.mstr && !modf_q;
    assign mosi_oe  = ctrl_q.en && ctrl_q.mstr && !modf_q;
    assign miso_oe  = ctrl_q.en && !ctrl_q.mstr && !ss_s && !modf_q;

    genvar g;
    generate
        for (g = 0; g < N_SSO; g++) begin : g_sso
            assign sso_n[g] = !(m_act && (tgt_q == TGT_W'(g)));
        end
    endgenerate

    // R5
    sso_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sso_n));

    // R7
    wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && busy) |=> wcol_q);

    // R8
    modf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (modf_q && !ctrl_q.mstr));

    // R8
    drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!sck_oe && !mosi_oe && !miso_oe));

endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       sck_in, sck_out, sck_oe;
    logic       mosi_in, mosi_out, mosi_oe;
    logic       miso_in, miso_out, miso_oe;
    logic       ss_n_in;
    logic [7:0] sso_n;

    int checks = 0;
    int fails = 0;

    // bench slave model state (used when the port is master)
    logic [7:0] m_tx = 8'h00;
    logic [7:0] m_rx = 8'h00;
    logic       m_cpha = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_n_in(ss_n_in), .sso_n(sso_n)
    );

    function automatic int exp_half(input int rate);
        return 2 << rate;
    endfunction

    function automatic logic [7:0] exp_sso(input int tgt);
        return ~(8'h01 << tgt);
    endfunction

    function automatic logic [7:0] ctrl_word(input bit mstr, input int mode, input int rate);
        return {1'b1, mstr, mode[1], mode[0], 1'b1, 1'b0, rate[1:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // slave model reacting to the port's master pins
    initial begin
        logic p_sel, p_sck, sel;
        int   edges;
        miso_in = 1'b0;
        p_sel = 1'b0; p_sck = 1'b0; edges = 0;
        forever begin
            @(negedge clk);
            sel = (sso_n != 8'hFF);
            if (sel && !p_sel) begin
                edges = 0; m_rx = 8'h00; miso_in = m_tx[7];
            end else if (sel && (sck_out != p_sck)) begin
                if ((edges % 2 == 0) == (m_cpha == 1'b0)) m_rx = {m_rx[6:0], mosi_out};
                if (!m_cpha && (edges % 2 == 1) && (edges < 15)) miso_in = m_tx[7 - (edges + 1) / 2];
                if (m_cpha && (edges % 2 == 0)) miso_in = m_tx[7 - edges / 2];
                edges++;
            end
            p_sel = sel; p_sck = sck_out;
        end
    end

    task automatic mxfer(input int mode, input int rate, input int tgt,
                         input logic [7:0] mb, input logic [7:0] sb, input bit mid_ctrl);
        logic [7:0] got, sso_seen;
        logic       ps;
        int         cyc, last, ntog, gap;
        wr(2'd1, 8'(tgt));
        wr(2'd0, ctrl_word(1'b1, mode, rate));
        m_tx = sb; m_cpha = mode[0];
        wr(2'd3, mb);
        ps = sck_out; cyc = 0; last = 0; ntog = 0; gap = 0; sso_seen = 8'hFF;
        while (!irq && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (sso_n != 8'hFF) sso_seen = sso_n;
            if (sck_out != ps) begin
                ntog++;
                if (ntog == 2) gap = cyc - last;
                last = cyc; ps = sck_out;
            end
            if (mid_ctrl && cyc == 5) begin
                reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ctrl_word(1'b1, mode ^ 2, 3);
                @(negedge clk); cyc++; reg_wr = 1'b0;
                if (sck_out != ps) begin ntog++; last = cyc; ps = sck_out; end
            end
            if (mid_ctrl && cyc == 9) begin
                reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = ~mb;
                @(negedge clk); cyc++; reg_wr = 1'b0;
                if (sck_out != ps) begin ntog++; last = cyc; ps = sck_out; end
            end
        end
        check(ntog == 16, "R3 sck edge count", ntog, 16);
        check(sck_out == mode[1], "R3 sck idle level", sck_out, mode[1]);
        check(gap == exp_half(rate), "R2 sck half period", gap, exp_half(rate));
        check(sso_seen == exp_sso(tgt), "R5 select output", sso_seen, exp_sso(tgt));
        check(sso_n == 8'hFF, "R5 select released", sso_n, 8'hFF);
        check(m_rx == mb, "R4 slave got master byte", m_rx, mb);
        rd(2'd3, got);
        check(got == sb, "R4 master got slave byte", got, sb);
        rd(2'd2, got);
        if (mid_ctrl) begin
            check(got == 8'hC0, "R7 done and collision flags", got, 8'hC0);
            rd(2'd0, got);
            check(got == ctrl_word(1'b1, mode, rate), "R3 mode fields frozen", got,
                  ctrl_word(1'b1, mode, rate));
            wr(2'd2, 8'hC0);
        end else begin
            check(got == 8'h80, "R6 done flag", got, 8'h80);
            wr(2'd2, 8'h80);
        end
        @(negedge clk);
        check(irq == 1'b0, "R6 irq cleared", irq, 0);
    endtask

    task automatic sxfer(input int mode, input logic [7:0] mb, input logic [7:0] sb);
        logic [7:0] got, rcv;
        logic       oe_seen;
        bit         cpha;
        cpha = mode[0];
        wr(2'd0, ctrl_word(1'b0, mode, 0));
        wr(2'd3, sb);
        @(negedge clk);
        sck_in = mode[1]; mosi_in = mb[7]; ss_n_in = 1'b0;
        rcv = 8'h00; oe_seen = 1'b0;
        repeat (HP) @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            if ((k % 2 == 0) == !cpha) rcv = {rcv[6:0], miso_out};
            if (k == 4) oe_seen = miso_oe;
            sck_in = ~sck_in;
            if (cpha && (k % 2 == 0)) mosi_in = mb[7 - k / 2];
            if (!cpha && (k % 2 == 1) && (k < 15)) mosi_in = mb[7 - (k + 1) / 2];
            repeat (HP) @(negedge clk);
        end
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
        check(oe_seen == 1'b1, "R9 miso driven while selected", oe_seen, 1);
        check(rcv == sb, "R9 master saw slave byte", rcv, sb);
        rd(2'd3, got);
        check(got == mb, "R9 slave got master byte", got, mb);
        check(irq == 1'b1, "R6 irq after slave byte", irq, 1);
        rd(2'd2, got);
        check(got == 8'h80, "R6 done after slave byte", got, 8'h80);
        wr(2'd2, 8'h80);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'h00;
        sck_in = 1'b0; mosi_in = 1'b0; ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check(v == 8'h00, "R1 ctrl reset", v, 0);
        rd(2'd1, v); check(v == 8'h00, "R1 sel reset", v, 0);
        rd(2'd2, v); check(v == 8'h00, "R1 stat reset", v, 0);
        check(sso_n == 8'hFF, "R1 selects high", sso_n, 8'hFF);
        check({sck_oe, mosi_oe, miso_oe, irq} == 4'b0, "R1 enables low",
              {sck_oe, mosi_oe, miso_oe, irq}, 0);

        // directed master exchanges, every mode and rate
        mxfer(0, 0, 0, 8'hA5, 8'h5A, 1'b0);
        mxfer(1, 1, 7, 8'hFF, 8'h00, 1'b0);
        mxfer(2, 2, 3, 8'h00, 8'hFF, 1'b0);
        mxfer(3, 3, 5, 8'h3C, 8'hC3, 1'b0);
        mxfer(1, 0, 2, 8'h81, 8'h7E, 1'b0);
        mxfer(3, 0, 6, 8'h96, 8'h69, 1'b0);

        // R7 and R3: collision and mode-field writes mid-transfer
        mxfer(0, 1, 4, 8'hB2, 8'h4D, 1'b1);

        // random master exchanges
        for (int i = 0; i < 10; i++) begin
            mxfer(int'($urandom % 4), int'($urandom % 4), int'($urandom % 8),
                  8'($urandom), 8'($urandom), 1'b0);
        end

        // R8 mode fault while master
        wr(2'd0, ctrl_word(1'b1, 0, 0));
        @(negedge clk); ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        check({sck_oe, mosi_oe, miso_oe} == 3'b0, "R8 drivers off",
              {sck_oe, mosi_oe, miso_oe}, 0);
        check(irq == 1'b1, "R8 irq on fault", irq, 1);
        rd(2'd2, v); check(v == 8'h20, "R8 fault flag", v, 8'h20);
        rd(2'd0, v); check(v[6] == 1'b0, "R8 master cleared", v[6], 0);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h20);
        rd(2'd2, v); check(v == 8'h00, "R6 fault flag cleared", v, 0);

        // slave exchanges, every mode
        sxfer(0, 8'hA5, 8'h3C);
        sxfer(1, 8'h00, 8'hFF);
        sxfer(2, 8'hFF, 8'h00);
        sxfer(3, 8'h5A, 8'hC3);

        // R10 clocking while deselected is ignored
        wr(2'd0, ctrl_word(1'b0, 0, 0));
        for (int k = 0; k < 16; k++) begin
            sck_in = ~sck_in; mosi_in = ~mosi_in;
            repeat (HP) @(negedge clk);
        end
        rd(2'd2, v); check(v == 8'h00, "R10 no done while deselected", v, 0);
        rd(2'd3, v); check(v == 8'h5A, "R10 data unchanged", v, 8'h5A);
        sck_in = 1'b0;

        for (int i = 0; i < 4; i++) begin
            sxfer(int'($urandom % 4), 8'($urandom), 8'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule